// File: doc/BRIEF.md
# SHA-512 Message Schedule Unit

This block computes the message schedule of the SHA-512 hash four 64-bit words at a time. A full update is split into two operations, chosen by a one-bit operation select. The partial operation adds the small sigma0 term of each word's upper neighbour to four consecutive schedule words. The completion operation adds small sigma1 terms, taken from the two most recent schedule words, to four partial sums.

Between the two operations, software adds the words from seven positions back to the partial sums, lane by lane. In the completion operation the two upper lanes are built from the two lower lanes of the same result, so that operation forms a two-step dependency chain inside a single cycle.

Operands arrive over a valid/ready handshake. The result is registered and held until the consumer takes it. Round constants, compression rounds, padding and message buffering are not part of this block.

Top module: `sha512_sched_unit`

## Requirements
- R1: Small sigma0 of x is ROTR(x,1) XOR ROTR(x,8) XOR (x >> 7), where ROTR is a 64-bit rotate right and >> is a logical shift.
- R2: With in_op = 0 (partial), word k of in_a is qword k (bits 64k+63 down to 64k), and in_b qword 0 serves as a fifth word. Result lane i = in_a.q[i] + sigma0(next), where next is in_a.q[i+1] for i < 3 and in_b.q0 for i = 3.
- R3: Small sigma1 of x is ROTR(x,19) XOR ROTR(x,61) XOR (x >> 6).
- R4: With in_op = 1 (completion), lane 0 = in_a.q0 + sigma1(in_b.q2) and lane 1 = in_a.q1 + sigma1(in_b.q3).
- R5: With in_op = 1, lane 2 = in_a.q2 + sigma1(lane 0 of the same result) and lane 3 = in_a.q3 + sigma1(lane 1 of the same result).
- R6: Every addition wraps modulo 2^64, and lane i of the result occupies out_data bits 64i+63 down to 64i.
- R7: A result appears on out_data with out_valid high at the clock edge that follows a cycle in which in_valid and in_ready are both high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R9: in_ready is low while out_valid is high and out_ready is low, and high otherwise. Inputs offered while in_ready is low are not taken.
- R10: A synchronous active-high reset clears out_valid. When no transfer is accepted, out_valid stays low.
- R11: In the partial operation in_b qwords 1 to 3 have no effect. In the completion operation in_b qwords 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and in_op are valid |
| in_ready | output | 1 | Unit can accept operands this cycle |
| in_op | input | 1 | 0 = partial (sigma0) step, 1 = completion (sigma1) step |
| in_a | input | 256 | Four schedule words or partial sums, lane 0 in the low bits |
| in_b | input | 256 | Look-ahead or recent words, depending on in_op |
| out_valid | output | 1 | Registered result is available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Registered four-lane result |

## Verification
On every cycle, the assertions check the handshake: latency after an accepted transfer, holding of valid and data under back-pressure, in_ready dropping while a result is stalled, and out_valid clearing on reset and staying low when idle. Only the bench's scenarios can show the arithmetic. It compares both operations against its own model of the complete 80-word schedule for several message blocks, and checks the modular wrap, the ignored operand words, and an input offered while the unit is stalled.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic {
    SMS_OP_PARTIAL = 1'b0,
    SMS_OP_FINISH  = 1'b1
  } sms_op_e;

  localparam int SMS_S0_ROT_A = 1;
  localparam int SMS_S0_ROT_B = 8;
  localparam int SMS_S0_SHR   = 7;
  localparam int SMS_S1_ROT_A = 19;
  localparam int SMS_S1_ROT_B = 61;
  localparam int SMS_S1_SHR   = 6;
  localparam int SMS_CHAIN    = 2;
endpackage

// File: rtl/sms_sigma.sv
module sms_sigma #(
  parameter int WORD_W = 64,
  parameter int ROT_A  = 1,
  parameter int ROT_B  = 8,
  parameter int SHR    = 7
) (
  input  logic [WORD_W-1:0] x,
  output logic [WORD_W-1:0] y
);
  logic [WORD_W-1:0] rot_a, rot_b, shr;

  always_comb begin
    rot_a = (x >> ROT_A) | (x << (WORD_W - ROT_A));
    rot_b = (x >> ROT_B) | (x << (WORD_W - ROT_B));
    shr   = x >> SHR;
    y     = rot_a ^ rot_b ^ shr;
  end
endmodule

// File: rtl/sms_partial.sv
module sms_partial
  import sms_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic [WORD_W*LANES-1:0] words,
  input  logic [WORD_W-1:0]       ahead,
  output logic [WORD_W*LANES-1:0] sums
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] nbr, sg;
    if (i == LANES - 1) begin : g_top
      assign nbr = ahead;
    end else begin : g_mid
      assign nbr = words[(i+1)*WORD_W +: WORD_W];
    end
    sms_sigma #(
      .WORD_W(WORD_W), .ROT_A(SMS_S0_ROT_A), .ROT_B(SMS_S0_ROT_B), .SHR(SMS_S0_SHR)
    ) u_sig (
      .x(nbr), .y(sg)
    );
    assign sums[i*WORD_W +: WORD_W] = words[i*WORD_W +: WORD_W] + sg;
  end
endmodule

// File: rtl/sms_finish.sv
module sms_finish
  import sms_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic [WORD_W*LANES-1:0] part,
  input  logic [WORD_W*LANES-1:0] recent,
  output logic [WORD_W*LANES-1:0] words
);
  localparam int DIST = SMS_CHAIN;

  logic [WORD_W-1:0] lane_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] src, sg;
    if (i < DIST) begin : g_ext
      assign src = recent[(LANES-DIST+i)*WORD_W +: WORD_W];
    end else begin : g_chain
      assign src = lane_q[i-DIST];
    end
    sms_sigma #(
      .WORD_W(WORD_W), .ROT_A(SMS_S1_ROT_A), .ROT_B(SMS_S1_ROT_B), .SHR(SMS_S1_SHR)
    ) u_sig (
      .x(src), .y(sg)
    );
    assign lane_q[i] = part[i*WORD_W +: WORD_W] + sg;
    assign words[i*WORD_W +: WORD_W] = lane_q[i];
  end
endmodule

// File: rtl/sms_outreg.sv
module sms_outreg #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= d;
    end
  end
endmodule

// File: rtl/sha512_sched_unit.sv
module sha512_sched_unit
  import sms_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_op,
  input  logic [WORD_W*LANES-1:0] in_a,
  input  logic [WORD_W*LANES-1:0] in_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W*LANES-1:0] out_data
);
  localparam int DATA_W = WORD_W * LANES;

  logic [DATA_W-1:0] part_res, fin_res, next_res;

  sms_partial #(.WORD_W(WORD_W), .LANES(LANES)) u_part (
    .words(in_a), .ahead(in_b[WORD_W-1:0]), .sums(part_res)
  );

  sms_finish #(.WORD_W(WORD_W), .LANES(LANES)) u_fin (
    .part(in_a), .recent(in_b), .words(fin_res)
  );

  always_comb begin
    next_res = (sms_op_e'(in_op) == SMS_OP_FINISH) ? fin_res : part_res;
  end

  sms_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .d(next_res), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );
endmodule

// File: rtl/sms_chk.sv
module sms_chk #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  AST_TAKE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);                                // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));      // R8
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);                             // R9
  AST_FREE_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);                                             // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid);                                                  // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !in_valid) |=> !out_valid);                            // R10
endmodule

bind sha512_sched_unit sms_chk #(.DATA_W(WORD_W*LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_sha512_sched_unit.sv
`timescale 1ns/1ps
module sim_sha512_sched_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_op = 1'b0;
  logic out_ready = 1'b1;
  logic [255:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [255:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sha512_sched_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  localparam logic [63:0] SEEDS [4] = '{
    64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF,
    64'h8000000000000001, 64'h5A5AC3C31E1E0F0F
  };

  function automatic logic [63:0] ror(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction
  function automatic logic [63:0] ref_s0(input logic [63:0] x);  // R1
    return ror(x, 1) ^ ror(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] ref_s1(input logic [63:0] x);  // R3
    return ror(x, 19) ^ ror(x, 61) ^ (x >> 6);
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [255:0] a, input logic [255:0] b,
                        output logic [255:0] r, output logic v);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    r = out_data;
    v = out_valid;
  endtask

  logic [63:0] w [80];
  logic [255:0] ra, rb, res, exp;
  logic vld;

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", {255'd0, out_valid}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle in_ready", {255'd0, in_ready}, 256'd1);

    // table-driven: full schedule per seed
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 16; j++) w[j] = SEEDS[s] * 64'(j + 3) ^ ror(SEEDS[s], j + 1);
      for (int j = 16; j < 80; j++)
        w[j] = ref_s1(w[j-2]) + w[j-7] + ref_s0(w[j-15]) + w[j-16];
      for (int t = 16; t < 80; t += 4) begin
        ra = {w[t-13], w[t-14], w[t-15], w[t-16]};
        rb = {64'hDEAD, 64'hBEEF, 64'hF00D, w[t-12]};
        run_op(1'b0, ra, rb, res, vld);
        for (int i = 0; i < 4; i++)
          exp[i*64 +: 64] = w[t-16+i] + ref_s0(w[t-15+i]);
        chk("R1/R2/R11 partial lanes", res, exp);
        for (int i = 0; i < 4; i++) ra[i*64 +: 64] = res[i*64 +: 64] + w[t-7+i];
        rb = {w[t-1], w[t-2], 64'h1111, 64'h2222};
        run_op(1'b1, ra, rb, res, vld);
        chk("R3/R4/R5/R6 finish vs schedule", res, {w[t+3], w[t+2], w[t+1], w[t]});
      end
      chk("R7 out_valid after take", {255'd0, vld}, 256'd1);
    end

    // R6 wrap: all-ones words, zero look-ahead
    run_op(1'b0, {4{64'hFFFFFFFFFFFFFFFF}}, 256'd0, res, vld);
    chk("R6 wrap", res, {64'hFFFFFFFFFFFFFFFF, {3{64'h01FFFFFFFFFFFFFE}}});

    // R11: ignored in_b words change nothing
    ra = {64'h1, 64'h2, 64'h3, 64'h4};
    run_op(1'b0, ra, {192'd0, 64'h77}, exp, vld);
    run_op(1'b0, ra, {{3{64'hFFFF0000FFFF0000}}, 64'h77}, res, vld);
    chk("R11 partial ignores b upper", res, exp);
    run_op(1'b1, ra, {64'h9, 64'h8, 128'd0}, exp, vld);
    run_op(1'b1, ra, {64'h9, 64'h8, {2{64'hA5A5A5A5A5A5A5A5}}}, res, vld);
    chk("R11 finish ignores b low", res, exp);
    chk("R4 finish lane0", {192'd0, res[63:0]}, {192'd0, 64'h4 + ref_s1(64'h8)});
    chk("R5 finish lane2 chain", {192'd0, res[191:128]},
        {192'd0, 64'h2 + ref_s1(64'h4 + ref_s1(64'h8))});

    // back-pressure
    out_ready = 1'b0;
    run_op(1'b0, ra, 256'd5, exp, vld);
    chk("R7 stalled valid", {255'd0, vld}, 256'd1);
    chk("R9 in_ready low when stalled", {255'd0, in_ready}, 256'd0);
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b1; in_a = ~ra; in_b = ~256'd0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R8 data held", out_data, exp);
    chk("R8 valid held", {255'd0, out_valid}, 256'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 offered input not taken", {255'd0, out_valid}, 256'd0);

    // reset clears pending result
    out_ready = 1'b0;
    run_op(1'b0, ra, 256'd0, res, vld);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset clears pending", {255'd0, out_valid}, 256'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 idle stays low", {255'd0, out_valid}, 256'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule